// File: doc/BRIEF.md
# Dual-Clock Word Buffer with Programmable Occupancy Flags

This block is a first-in first-out store for 18-bit words. One side writes on its own clock and the other side reads on a second clock. The two clocks may be unrelated, or they may be the same net. The depth is set by a parameter, from 256 up to 4,096 words. Occupancy crosses between the two domains as Gray-coded pointers through a synchronizer chain. A parameter sets that chain to one or two flops.

The read side has two modes, and the mode is latched while reset is held. In standard mode each word is presented only after a read request, and the two edge flags report empty and full. In look-ahead mode the oldest word appears on the output by itself. In that mode the empty-side flag reports that a word is ready on the output, and the full-side flag reports that a write can be accepted. Three further flags are provided: an almost-empty flag, an almost-full flag and a half-full flag. The almost-empty and almost-full thresholds are set by offsets that are loaded through the write port. A parameter chooses whether the almost flags are registered in their own clock domain or driven straight from the pointer compare.

Top module: `fifo_dc`

## Requirements
- R1: After reset, in standard mode: `empty_or`=1, `full_ir`=0, `almost_empty`=1, `almost_full`=0, `half_full`=0 and `dout`=0. Both offsets default to 31 words, so `almost_empty` stays 1 with 31 words stored and drops to 0 with 32.
- R2: In standard mode, words leave in the order they were written. A read request accepted at a read-clock edge updates `dout` at that same edge.
- R3: Once DEPTH words are stored, `full_ir`=1 in standard mode. A further write is dropped: it neither stores data nor moves the write pointer.
- R4: In standard mode, a read while `empty_or`=1 is ignored. `dout` keeps its last value and the read pointer does not move.
- R5: In look-ahead mode (`fwft_sel`=1 during reset), the oldest word appears on `dout` with no read request, and `empty_or`=1 means a word is on the output. `full_ir`=1 means a write can be accepted. The word on the output has already left the storage, so `full_ir` drops to 0 only when DEPTH+1 words are held in total. While `ren`=0, the presented word stays in place.
- R6: A write with `load`=1 is not stored in the buffer. The first such write after reset loads the almost-empty offset from `din[AW-1:0]`. The second loads the almost-full offset. The loads then keep alternating between the two.
- R7: `almost_empty`=1 when the stored count is at most the almost-empty offset. `almost_full`=1 when the stored count is at least DEPTH minus the almost-full offset.
- R8: `half_full`=1 when the stored count exceeds DEPTH/2.
- R9: While `oe`=0, `dout` reads 0. Raising `oe` again shows the held word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset; must be held across edges of both clocks |
| fwft_sel | input | 1 | Read mode, latched during reset: 0 standard, 1 look-ahead |
| wen | input | 1 | Write request |
| load | input | 1 | With `wen`, writes an offset instead of data |
| din | input | 18 | Write data or offset value |
| ren | input | 1 | Read request |
| oe | input | 1 | Output gate; 0 forces `dout` to zero |
| dout | output | 18 | Read data |
| full_ir | output | 1 | Standard: full. Look-ahead: input ready |
| empty_or | output | 1 | Standard: empty. Look-ahead: output ready |
| almost_full | output | 1 | Stored count at or above DEPTH minus the offset |
| almost_empty | output | 1 | Stored count at or below the offset |
| half_full | output | 1 | Stored count above DEPTH/2 |

## Verification
The read and write clocks run at unrelated periods, so the pointer crossing is exercised on every transfer. Each flag is sampled just below and just above its threshold: the default almost-empty offset at 31 and 32 words, loaded offsets at 4 and 5 words and at 247 and 248 words, and half-full at 128 and 129 words. Because the fill pattern is distinct at every index and is read back in full after a write to a full buffer, a dropped write can be told apart from a stored one, and a reordering from a stall. Standard and look-ahead runs start from the same stimulus and differ only in the reset-time mode, which separates the request-driven presentation of words from the fall-through presentation and shows the extra word of capacity in look-ahead mode.

// File: rtl/fifo_dc_pkg.sv
package fifo_dc_pkg;

    localparam int DATA_W      = 18;
    localparam int OFFSET_INIT = 31;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } rd_mode_e;

    typedef struct packed {
        logic full;
        logic almost_full;
        logic half_full;
    } wr_flags_t;

    typedef struct packed {
        logic empty_or;
        logic almost_empty;
    } rd_flags_t;

    function automatic logic legal_depth(int d);
        return (d == 256) || (d == 512) || (d == 1024) || (d == 2048) || (d == 4096);
    endfunction

endpackage

// File: rtl/fifo_dc_sync.sv
module fifo_dc_sync #(
    parameter int W      = 9,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/fifo_dc_wr.sv
module fifo_dc_wr
    import fifo_dc_pkg::*;
#(
    parameter int DEPTH      = 256,
    parameter bit ALMOST_REG = 1'b1,
    localparam int AW        = $clog2(DEPTH),
    localparam int PW        = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fwft_sel,
    input  logic          wen,
    input  logic          load,
    input  logic [AW-1:0] off_data,
    input  logic [PW-1:0] rgray_s,
    output logic [PW-1:0] wgray,
    output logic [AW-1:0] waddr,
    output logic          we,
    output logic [AW-1:0] ae_off,
    output rd_mode_e      mode,
    output wr_flags_t     flags
);

    logic [PW-1:0] wbin_q, wbin_nx, rbin_s, level;
    logic [PW-1:0] wgray_q;
    logic [AW-1:0] ae_q, af_q;
    logic          sel_q;
    logic          full, af_now, af_out;
    rd_mode_e      mode_q;

    always_comb begin
        rbin_s[PW-1] = rgray_s[PW-1];
        for (int i = PW - 2; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
    end

    assign level   = wbin_q - rbin_s;
    assign full    = (level == PW'(DEPTH));
    assign we      = wen && !load && !full;
    assign wbin_nx = wbin_q + PW'(we);

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin_q  <= '0;
            wgray_q <= '0;
            mode_q  <= rd_mode_e'(fwft_sel);
            sel_q   <= 1'b0;
            ae_q    <= AW'(OFFSET_INIT);
            af_q    <= AW'(OFFSET_INIT);
        end else begin
            wbin_q  <= wbin_nx;
            wgray_q <= wbin_nx ^ (wbin_nx >> 1);
            if (wen && load) begin
                if (!sel_q) ae_q <= off_data;
                else        af_q <= off_data;
                sel_q <= ~sel_q;
            end
        end
    end

    assign af_now = (level >= (PW'(DEPTH) - {1'b0, af_q}));

    generate
        if (ALMOST_REG) begin : g_af_reg
            logic af_r;
            always_ff @(posedge clk) begin
                if (rst) af_r <= 1'b0;
                else     af_r <= af_now;
            end
            assign af_out = af_r;
        end else begin : g_af_comb
            assign af_out = af_now;
        end
    endgenerate

    always_comb begin
        flags.full        = full;
        flags.almost_full = af_out;
        flags.half_full   = (level > PW'(DEPTH / 2));
    end

    assign wgray  = wgray_q;
    assign waddr  = wbin_q[AW-1:0];
    assign ae_off = ae_q;
    assign mode   = mode_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (wen && !load && full) |=> (wbin_q == $past(wbin_q))) else $error("write past full"); // R3
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        level <= PW'(DEPTH)) else $error("level out of range"); // R3
    AST_LOAD_NOT_STORED: assert property (@(posedge clk) disable iff (rst)
        (wen && load) |=> $stable(wbin_q)) else $error("offset load stored"); // R6

endmodule

// File: rtl/fifo_dc_rd.sv
module fifo_dc_rd
    import fifo_dc_pkg::*;
#(
    parameter int DEPTH      = 256,
    parameter bit ALMOST_REG = 1'b1,
    localparam int AW        = $clog2(DEPTH),
    localparam int PW        = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fwft_sel,
    input  logic          ren,
    input  logic [PW-1:0] wgray_s,
    input  logic [AW-1:0] ae_off,
    output logic [PW-1:0] rgray,
    output logic [AW-1:0] raddr,
    output logic          fetch,
    output rd_flags_t     flags
);

    logic [PW-1:0] rbin_q, rbin_nx, rgray_q, wbin_s, level;
    logic          ram_empty, ov_q, ae_now, ae_out;
    rd_mode_e      mode_q;

    always_comb begin
        wbin_s[PW-1] = wgray_s[PW-1];
        for (int i = PW - 2; i >= 0; i--) wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
    end

    assign ram_empty = (rgray_q == wgray_s);
    assign level     = wbin_s - rbin_q;

    always_comb begin
        if (mode_q == MODE_FWFT) fetch = (!ov_q || ren) && !ram_empty;
        else                     fetch = ren && !ram_empty;
    end

    assign rbin_nx = rbin_q + PW'(fetch);

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin_q  <= '0;
            rgray_q <= '0;
            ov_q    <= 1'b0;
            mode_q  <= rd_mode_e'(fwft_sel);
        end else begin
            rbin_q  <= rbin_nx;
            rgray_q <= rbin_nx ^ (rbin_nx >> 1);
            if (fetch)    ov_q <= 1'b1;
            else if (ren) ov_q <= 1'b0;
        end
    end

    assign ae_now = (level <= {1'b0, ae_off});

    generate
        if (ALMOST_REG) begin : g_ae_reg
            logic ae_r;
            always_ff @(posedge clk) begin
                if (rst) ae_r <= 1'b1;
                else     ae_r <= ae_now;
            end
            assign ae_out = ae_r;
        end else begin : g_ae_comb
            assign ae_out = ae_now;
        end
    endgenerate

    always_comb begin
        flags.empty_or     = (mode_q == MODE_FWFT) ? ov_q : ram_empty;
        flags.almost_empty = ae_out;
    end

    assign rgray = rgray_q;
    assign raddr = rbin_q[AW-1:0];

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_STD && ren && ram_empty) |=> $stable(rbin_q)) else $error("read past empty"); // R4
    AST_FWFT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_FWFT && ov_q && !ren) |=> (ov_q && $stable(rbin_q))) else $error("presented word lost"); // R5

endmodule

// File: rtl/fifo_dc.sv
module fifo_dc
    import fifo_dc_pkg::*;
#(
    parameter int DEPTH       = 256,
    parameter int FLAG_STAGES = 2,
    parameter bit ALMOST_REG  = 1'b1,
    localparam int AW         = $clog2(DEPTH),
    localparam int PW         = AW + 1
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst,
    input  logic              fwft_sel,
    input  logic              wen,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              ren,
    input  logic              oe,
    output logic [DATA_W-1:0] dout,
    output logic              full_ir,
    output logic              empty_or,
    output logic              almost_full,
    output logic              almost_empty,
    output logic              half_full
);

    logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
    logic [AW-1:0] waddr, raddr, ae_off;
    logic          we, fetch;
    rd_mode_e      mode_w;
    wr_flags_t     wflags;
    rd_flags_t     rflags;
    word_t         mem [DEPTH];
    word_t         q_r;

    fifo_dc_wr #(.DEPTH(DEPTH), .ALMOST_REG(ALMOST_REG)) u_wr (
        .clk(wclk), .rst(rst), .fwft_sel(fwft_sel), .wen(wen), .load(load),
        .off_data(din[AW-1:0]), .rgray_s(rgray_s), .wgray(wgray), .waddr(waddr),
        .we(we), .ae_off(ae_off), .mode(mode_w), .flags(wflags)
    );

    fifo_dc_rd #(.DEPTH(DEPTH), .ALMOST_REG(ALMOST_REG)) u_rd (
        .clk(rclk), .rst(rst), .fwft_sel(fwft_sel), .ren(ren), .wgray_s(wgray_s),
        .ae_off(ae_off), .rgray(rgray), .raddr(raddr), .fetch(fetch), .flags(rflags)
    );

    fifo_dc_sync #(.W(PW), .STAGES(FLAG_STAGES)) u_w2r (
        .clk(rclk), .rst(rst), .d(wgray), .q(wgray_s)
    );

    fifo_dc_sync #(.W(PW), .STAGES(FLAG_STAGES)) u_r2w (
        .clk(wclk), .rst(rst), .d(rgray), .q(rgray_s)
    );

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= din;
    end

    always_ff @(posedge rclk) begin
        if (rst)        q_r <= '0;
        else if (fetch) q_r <= mem[raddr];
    end

    assign dout         = oe ? q_r : '0;
    assign full_ir      = (mode_w == MODE_FWFT) ? ~wflags.full : wflags.full;
    assign empty_or     = rflags.empty_or;
    assign almost_full  = wflags.almost_full;
    assign almost_empty = rflags.almost_empty;
    assign half_full    = wflags.half_full;

    AST_DATA_HELD: assert property (@(posedge rclk) disable iff (rst)
        !fetch |=> $stable(q_r)) else $error("output word changed without fetch"); // R4

endmodule

// File: tb/test_fifo_dc.sv
`timescale 1ns/1ps
module test_fifo_dc;

    localparam int D = 256;

    logic        wclk = 1'b0, rclk = 1'b0;
    logic        rst = 1'b1, fwft_sel = 1'b0, wen = 1'b0, load = 1'b0, ren = 1'b0, oe = 1'b1;
    logic [17:0] din = '0;
    logic [17:0] dout;
    logic        full_ir, empty_or, almost_full, almost_empty, half_full;

    int nchk = 0, nfail = 0;
    bit done = 1'b0;

    always #2.5 wclk = ~wclk;
    always #3.5 rclk = ~rclk;

    fifo_dc #(.DEPTH(D), .FLAG_STAGES(2), .ALMOST_REG(1'b1)) i_fifo_dc (
        .wclk(wclk), .rclk(rclk), .rst(rst), .fwft_sel(fwft_sel), .wen(wen),
        .load(load), .din(din), .ren(ren), .oe(oe), .dout(dout), .full_ir(full_ir),
        .empty_or(empty_or), .almost_full(almost_full), .almost_empty(almost_empty),
        .half_full(half_full)
    );

    function automatic logic [17:0] pat(int i, int s);
        return 18'((i * 37 + s * 1021 + 5) & 32'h3FFFF);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge rclk);
        repeat (8) @(negedge wclk);
    endtask

    task automatic do_reset(input logic mode);
        rst = 1'b1;
        fwft_sel = mode;
        repeat (4) @(negedge wclk);
        repeat (4) @(negedge rclk);
        @(negedge wclk) rst = 1'b0;
        settle();
    endtask

    task automatic wr(input logic [17:0] d, input logic ld);
        @(negedge wclk);
        wen = 1'b1; load = ld; din = d;
        @(negedge wclk);
        wen = 1'b0; load = 1'b0;
    endtask

    task automatic rd_pulse();
        @(negedge rclk) ren = 1'b1;
        @(negedge rclk) ren = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset(1'b0);
        chk("R1 empty", 32'(empty_or), 1);
        chk("R1 full", 32'(full_ir), 0);
        chk("R1 almost_empty", 32'(almost_empty), 1);
        chk("R1 almost_full", 32'(almost_full), 0);
        chk("R1 half_full", 32'(half_full), 0);
        chk("R1 dout", 32'(dout), 0);
    endtask

    task automatic t_default_order();
        for (int i = 0; i < 32; i++) begin
            wr(pat(i, 1), 1'b0);
            if (i == 30) begin settle(); chk("R1 R7 ae at 31 words", 32'(almost_empty), 1); end
        end
        settle();
        chk("R1 R7 ae at 32 words", 32'(almost_empty), 0);
        chk("R2 not empty", 32'(empty_or), 0);
        for (int i = 0; i < 32; i++) begin
            rd_pulse();
            chk("R2 order", 32'(dout), 32'(pat(i, 1)));
        end
        settle();
        chk("R2 drained", 32'(empty_or), 1);
        rd_pulse();
        chk("R4 dout held on empty read", 32'(dout), 32'(pat(31, 1)));
        settle();
        chk("R4 still empty", 32'(empty_or), 1);
    endtask

    task automatic t_offsets_and_fill();
        wr(18'd4, 1'b1);
        wr(18'd8, 1'b1);
        settle();
        chk("R6 load not stored", 32'(empty_or), 1);
        for (int i = 0; i < D; i++) begin
            wr(pat(i, 3), 1'b0);
            if (i == 3)   begin settle(); chk("R6 R7 ae at 4", 32'(almost_empty), 1); end
            if (i == 4)   begin settle(); chk("R6 R7 ae at 5", 32'(almost_empty), 0); end
            if (i == 127) begin settle(); chk("R8 hf at 128", 32'(half_full), 0); end
            if (i == 128) begin settle(); chk("R8 hf at 129", 32'(half_full), 1); end
            if (i == 246) begin settle(); chk("R6 R7 af at 247", 32'(almost_full), 0); end
            if (i == 247) begin settle(); chk("R6 R7 af at 248", 32'(almost_full), 1); end
            if (i == 254) begin settle(); chk("R3 not full at 255", 32'(full_ir), 0); end
        end
        settle();
        chk("R3 full at depth", 32'(full_ir), 1);
        wr(18'h2AAAA, 1'b0);
        settle();
        for (int i = 0; i < D; i++) begin
            rd_pulse();
            chk("R3 content after dropped write", 32'(dout), 32'(pat(i, 3)));
        end
        settle();
        chk("R3 extra write not stored", 32'(empty_or), 1);
    endtask

    task automatic t_output_gate();
        wr(18'h1F0F0, 1'b0);
        settle();
        rd_pulse();
        chk("R9 word with oe high", 32'(dout), 32'h1F0F0);
        @(negedge rclk) oe = 1'b0;
        #1;
        chk("R9 zero with oe low", 32'(dout), 0);
        @(negedge rclk) oe = 1'b1;
        #1;
        chk("R9 word restored", 32'(dout), 32'h1F0F0);
    endtask

    task automatic t_lookahead();
        do_reset(1'b1);
        chk("R5 no word ready after reset", 32'(empty_or), 0);
        chk("R5 input ready after reset", 32'(full_ir), 1);
        wr(pat(0, 5), 1'b0);
        settle();
        chk("R5 output ready", 32'(empty_or), 1);
        chk("R5 word falls through", 32'(dout), 32'(pat(0, 5)));
        for (int i = 1; i <= D; i++) begin
            wr(pat(i, 5), 1'b0);
            if (i == D - 1) begin settle(); chk("R5 ready below capacity", 32'(full_ir), 1); end
        end
        settle();
        chk("R5 not ready at depth plus one", 32'(full_ir), 0);
        chk("R5 presented word held", 32'(dout), 32'(pat(0, 5)));
        wr(18'h15555, 1'b0);
        settle();
        for (int i = 0; i <= D; i++) begin
            chk("R5 order", 32'(dout), 32'(pat(i, 5)));
            rd_pulse();
        end
        settle();
        chk("R5 no word after drain", 32'(empty_or), 0);
    endtask

    initial begin
        t_reset_state();
        t_default_order();
        t_offsets_and_fill();
        t_output_gate();
        t_lookahead();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge wclk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule